// File: doc/BRIEF.md
# Pipelined Bresenham Line Rasterizer

The block turns a pair of unsigned endpoint coordinates into the ordered list of grid pixels that approximate the straight segment between them, using integer error accumulation only (no division, no multiplication). A client pulses `start` with a source point and a destination point. The block then spends exactly one cycle deriving the absolute spans, the step directions and the seed of the error term. After that it emits one pixel coordinate on every clock until it reaches the destination, which suits a frame-buffer write port that takes one write per cycle.

The control is a three-state machine. `ST_IDLE` waits for a start pulse and latches both endpoints. Transition *accept* goes `ST_IDLE` to `ST_SETUP`. `ST_SETUP` loads the span, direction and error registers and places the cursor on the source point. Transition *prime* goes `ST_SETUP` to `ST_DRAW`. `ST_DRAW` presents the cursor as a valid pixel and advances it one step. Transition *finish* returns to `ST_IDLE` in the cycle the cursor sits on the destination. All eight octants, reversed directions, axis-aligned segments and single-point segments go through the same step logic.

Top module: `line_raster`

## Requirements
- R1: While and directly after reset, `busy`, `pix_valid` and `line_done` are 0.
- R2: A `start` seen while `busy` is 0 makes `busy` 1 in the next cycle with `pix_valid` still 0 (the setup cycle). The first valid pixel follows in the cycle after that and equals the source point. Coordinates are unsigned, `COORD_W` bits wide.
- R3: From the first pixel until `line_done`, `pix_valid` is 1 in every cycle, so one pixel is delivered per clock.
- R4: A segment yields exactly max(|dst_x-src_x|, |dst_y-src_y|)+1 pixels. `line_done` is 1 only together with the last one, and the last one equals the destination point.
- R5: Between consecutive pixels the coordinate along the longer span moves by exactly one toward the destination. The other coordinate moves by zero or one toward the destination.
- R6: Every pixel lies within half a pixel of the ideal segment, measured along the shorter span: |2·(j·ax − i·ay)| ≤ max(ax, ay). Here ax and ay are the absolute spans, and i and j are the pixel's absolute offsets from the source.
- R7: A segment whose source equals its destination yields a single pixel, and `line_done` is set on that pixel.
- R8: A `start` pulse while `busy` is 1 has no effect: the segment in progress completes unchanged.
- R9: `busy` is 0 in the cycle after `line_done`, and a new `start` is accepted from that cycle on.
- R10: On horizontal or vertical segments the coordinate that does not change between the endpoints keeps its value on every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a segment; honoured only while idle |
| src_x | input | COORD_W | Source point, x |
| src_y | input | COORD_W | Source point, y |
| dst_x | input | COORD_W | Destination point, x |
| dst_y | input | COORD_W | Destination point, y |
| busy | output | 1 | Segment in setup or drawing |
| pix_valid | output | 1 | `pix_x`/`pix_y` carry a pixel this cycle |
| pix_x | output | COORD_W | Pixel x |
| pix_y | output | COORD_W | Pixel y |
| line_done | output | 1 | This pixel is the destination point |

## Verification
The bench targets the cases an error-term rasterizer most often gets wrong. The first is a single-point segment: a wrong design would never assert completion or would emit a second pixel. The next are exact diagonals and ties, where both axes must step in one cycle: a design that steps only one axis per cycle would double the pixel count. Right-to-left and bottom-to-top segments come next, where a wrong sign would walk away from the destination and overrun. Full-range coordinates would overflow a too-narrow error register and bend the line beyond the half-pixel bound. A start pulse injected mid-segment would corrupt the cursor if the endpoints were re-latched while busy. Random segments are checked against bench-computed counts, step rules and the distance bound, not against a copied algorithm.

// File: rtl/line_raster_pkg.sv
package line_raster_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DRAW  = 2'd2
    } raster_state_e;

    // Extra error-term bits over the coordinate width: one for sign,
    // one for the doubled comparison term, one for the dual-axis add.
    localparam int ERR_GUARD = 3;

endpackage

// File: rtl/line_setup.sv
module line_setup #(
    parameter int COORD_W = 11,
    parameter int ERR_W   = COORD_W + 3
) (
    input  logic [COORD_W-1:0]      a_x,
    input  logic [COORD_W-1:0]      a_y,
    input  logic [COORD_W-1:0]      b_x,
    input  logic [COORD_W-1:0]      b_y,
    output logic signed [ERR_W-1:0] span_x,
    output logic signed [ERR_W-1:0] span_y,
    output logic signed [ERR_W-1:0] err_seed,
    output logic                    neg_x,
    output logic                    neg_y
);

    localparam int PAD = ERR_W - COORD_W;

    logic [COORD_W-1:0] mag_x;
    logic [COORD_W-1:0] mag_y;

    always_comb begin
        neg_x    = (b_x < a_x);
        neg_y    = (b_y < a_y);
        mag_x    = neg_x ? (a_x - b_x) : (b_x - a_x);
        mag_y    = neg_y ? (a_y - b_y) : (b_y - a_y);
        // x span kept positive, y span kept negative
        span_x   = $signed({{PAD{1'b0}}, mag_x});
        span_y   = -$signed({{PAD{1'b0}}, mag_y});
        err_seed = span_x + span_y;
    end

endmodule

// File: rtl/line_step.sv
module line_step #(
    parameter int COORD_W = 11,
    parameter int ERR_W   = COORD_W + 3
) (
    input  logic [COORD_W-1:0]      cur_x,
    input  logic [COORD_W-1:0]      cur_y,
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [ERR_W-1:0] span_x,
    input  logic signed [ERR_W-1:0] span_y,
    input  logic                    neg_x,
    input  logic                    neg_y,
    output logic [COORD_W-1:0]      nxt_x,
    output logic [COORD_W-1:0]      nxt_y,
    output logic signed [ERR_W-1:0] nxt_err
);

    localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

    logic signed [ERR_W:0] twice;
    logic signed [ERR_W:0] wide_sx;
    logic signed [ERR_W:0] wide_sy;
    logic                  adv_x;
    logic                  adv_y;

    always_comb begin
        twice   = {err, 1'b0};
        wide_sx = span_x;
        wide_sy = span_y;
        adv_x   = (twice >= wide_sy);
        adv_y   = (twice <= wide_sx);
        nxt_err = err + (adv_x ? span_y : '0) + (adv_y ? span_x : '0);
        nxt_x   = cur_x;
        nxt_y   = cur_y;
        if (adv_x) nxt_x = neg_x ? (cur_x - ONE) : (cur_x + ONE);
        if (adv_y) nxt_y = neg_y ? (cur_y - ONE) : (cur_y + ONE);
    end

endmodule

// File: rtl/line_raster.sv
module line_raster
    import line_raster_pkg::*;
#(
    parameter int COORD_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic               busy,
    output logic               pix_valid,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y,
    output logic               line_done
);

    localparam int ERR_W = COORD_W + ERR_GUARD;

    raster_state_e state_q, state_d;

    // latched endpoints
    logic [COORD_W-1:0] a_x_q, a_y_q, b_x_q, b_y_q;
    // walking state
    logic [COORD_W-1:0]      cur_x_q, cur_y_q;
    logic signed [ERR_W-1:0] err_q, span_x_q, span_y_q;
    logic                    neg_x_q, neg_y_q;

    // setup results
    logic signed [ERR_W-1:0] set_sx, set_sy, set_err;
    logic                    set_nx, set_ny;
    // step results
    logic [COORD_W-1:0]      stp_x, stp_y;
    logic signed [ERR_W-1:0] stp_err;

    logic at_end;

    line_setup #(.COORD_W(COORD_W), .ERR_W(ERR_W)) u_setup (
        .a_x      (a_x_q),
        .a_y      (a_y_q),
        .b_x      (b_x_q),
        .b_y      (b_y_q),
        .span_x   (set_sx),
        .span_y   (set_sy),
        .err_seed (set_err),
        .neg_x    (set_nx),
        .neg_y    (set_ny)
    );

    line_step #(.COORD_W(COORD_W), .ERR_W(ERR_W)) u_step (
        .cur_x   (cur_x_q),
        .cur_y   (cur_y_q),
        .err     (err_q),
        .span_x  (span_x_q),
        .span_y  (span_y_q),
        .neg_x   (neg_x_q),
        .neg_y   (neg_y_q),
        .nxt_x   (stp_x),
        .nxt_y   (stp_y),
        .nxt_err (stp_err)
    );

    assign at_end = (cur_x_q == b_x_q) && (cur_y_q == b_y_q);

    // next-state logic: accept, prime, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)  state_d = ST_SETUP;
            ST_SETUP:             state_d = ST_DRAW;
            ST_DRAW:  if (at_end) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_x_q    <= '0;
            a_y_q    <= '0;
            b_x_q    <= '0;
            b_y_q    <= '0;
            cur_x_q  <= '0;
            cur_y_q  <= '0;
            err_q    <= '0;
            span_x_q <= '0;
            span_y_q <= '0;
            neg_x_q  <= 1'b0;
            neg_y_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_x_q <= src_x;
                        a_y_q <= src_y;
                        b_x_q <= dst_x;
                        b_y_q <= dst_y;
                    end
                end
                ST_SETUP: begin
                    cur_x_q  <= a_x_q;
                    cur_y_q  <= a_y_q;
                    err_q    <= set_err;
                    span_x_q <= set_sx;
                    span_y_q <= set_sy;
                    neg_x_q  <= set_nx;
                    neg_y_q  <= set_ny;
                end
                ST_DRAW: begin
                    if (!at_end) begin
                        cur_x_q <= stp_x;
                        cur_y_q <= stp_y;
                        err_q   <= stp_err;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        pix_valid = (state_q == ST_DRAW);
        pix_x     = cur_x_q;
        pix_y     = cur_y_q;
        line_done = (state_q == ST_DRAW) && at_end;
    end

endmodule

// File: rtl/line_raster_chk.sv
module line_raster_chk #(
    parameter int COORD_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic               line_done
);

    logic [COORD_W-1:0] prev_x, prev_y, dlt_x, dlt_y;
    logic               near_x, near_y, moved;

    always_ff @(posedge clk) begin
        prev_x <= pix_x;
        prev_y <= pix_y;
    end

    always_comb begin
        dlt_x  = pix_x - prev_x;
        dlt_y  = pix_y - prev_y;
        near_x = (dlt_x == '0) || (dlt_x == COORD_W'(1)) || (dlt_x == '1);
        near_y = (dlt_y == '0) || (dlt_y == COORD_W'(1)) || (dlt_y == '1);
        moved  = (dlt_x != '0) || (dlt_y != '0);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !busy && !pix_valid && !line_done);

    assert_setup_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !pix_valid);

    assert_setup_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pix_valid |=> pix_valid);

    assert_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !line_done |=> pix_valid);

    assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy);

    assert_done_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> pix_valid);

    assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !line_done |=> near_x && near_y && moved);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && start && !line_done |=> pix_valid);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !busy);

endmodule

bind line_raster line_raster_chk #(.COORD_W(COORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .line_done (line_done)
);

// File: tb/line_raster_test.sv
module line_raster_test;

    localparam int CW   = 11;
    localparam int MAXC = (1 << CW) - 1;
    localparam int WD   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
    logic          busy, pix_valid, line_done;
    logic [CW-1:0] pix_x, pix_y;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    line_raster #(.COORD_W(CW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_x     (src_x),
        .src_y     (src_y),
        .dst_x     (dst_x),
        .dst_y     (dst_y),
        .busy      (busy),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .line_done (line_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int sgn(input int v);
        return (v < 0) ? -1 : 1;
    endfunction

    // half-pixel distance test computed from the requirement
    function automatic bit on_line(input int ax, ay, bx, by, px, py);
        longint sx, sy, i, j, d, m;
        sx = iabs(bx - ax); sy = iabs(by - ay);
        i  = iabs(px - ax); j  = iabs(py - ay);
        d  = 2 * (j * sx - i * sy);
        if (d < 0) d = -d;
        m  = (sx > sy) ? sx : sy;
        return d <= m;
    endfunction

    // entered and left just after a falling edge, with the block idle
    task automatic run_line(input int ax, ay, bx, by, input int inject);
        int  sx, sy, nmax, cnt, px, py, qx, qy, ddx, ddy;
        bit  fin, xmaj;
        sx   = iabs(bx - ax);
        sy   = iabs(by - ay);
        nmax = ((sx > sy) ? sx : sy) + 1;
        xmaj = (sx >= sy);
        src_x = CW'(ax); src_y = CW'(ay); dst_x = CW'(bx); dst_y = CW'(by);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !pix_valid, "R2 setup cycle", {busy, pix_valid}, 2'b10);
        cnt = 0; fin = 0; qx = ax; qy = ay;
        while (!fin) begin
            @(negedge clk);
            if (start) begin
                start = 1'b0;
            end
            if (!pix_valid) begin
                check(1'b0, "R3 stream gap", cnt, nmax);
                fin = 1;
            end else begin
                px = int'(pix_x); py = int'(pix_y);
                if (cnt == 0) begin
                    check(px == ax && py == ay, "R2 first pixel", px * 4096 + py, ax * 4096 + ay);
                end else begin
                    ddx = px - qx; ddy = py - qy;
                    if (xmaj) begin
                        check(ddx == sgn(bx - ax), "R5 major x step", ddx, sgn(bx - ax));
                        check(ddy == 0 || ddy == sgn(by - ay), "R5 minor y step", ddy, sgn(by - ay));
                    end else begin
                        check(ddy == sgn(by - ay), "R5 major y step", ddy, sgn(by - ay));
                        check(ddx == 0 || ddx == sgn(bx - ax), "R5 minor x step", ddx, sgn(bx - ax));
                    end
                    if (sx == 0) check(px == ax, "R10 vertical x held", px, ax);
                    if (sy == 0) check(py == ay, "R10 horizontal y held", py, ay);
                end
                check(on_line(ax, ay, bx, by, px, py), "R6 distance", px * 4096 + py, -1);
                cnt++;
                qx = px; qy = py;
                if (line_done) begin
                    fin = 1;
                    check(cnt == nmax, "R4 pixel count", cnt, nmax);
                    check(px == bx && py == by, "R4 last pixel", px * 4096 + py, bx * 4096 + by);
                    if (sx == 0 && sy == 0) check(cnt == 1, "R7 single point", cnt, 1);
                end else if (cnt >= nmax) begin
                    check(1'b0, "R4 overrun without done", cnt, nmax);
                    fin = 1;
                end else if (cnt == inject) begin
                    // R8: foreign start while busy
                    start = 1'b1;
                    src_x = CW'($urandom); src_y = CW'($urandom);
                    dst_x = CW'($urandom); dst_y = CW'($urandom);
                end
            end
        end
        while (pix_valid) @(negedge clk);
        check(!busy, "R9 released", busy, 0);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        check(1'b0, "watchdog", WD, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h1D5E_ED07);
        repeat (3) @(negedge clk);
        check(!busy && !pix_valid && !line_done, "R1 in reset", {busy, pix_valid, line_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !pix_valid && !line_done, "R1 after reset", {busy, pix_valid, line_done}, 0);

        // directed corners
        run_line(5, 5, 5, 5, -1);              // R7
        run_line(0, 0, 0, 0, -1);              // R7 at origin
        run_line(10, 20, 30, 20, -1);          // R10 left to right
        run_line(30, 20, 10, 20, -1);          // R10 right to left
        run_line(40, 3, 40, 25, -1);           // R10 downwards
        run_line(40, 25, 40, 3, -1);           // R10 upwards
        run_line(0, 0, 9, 9, -1);              // diagonal
        run_line(9, 0, 0, 9, -1);
        run_line(9, 9, 0, 0, -1);
        run_line(0, 9, 9, 0, -1);
        run_line(1, 2, 4, 13, -1);             // steep octants
        run_line(4, 13, 1, 2, -1);
        run_line(0, 0, 7, 2, -1);              // tie-prone
        run_line(3, 3, 4, 4, -1);
        run_line(0, 0, MAXC, MAXC, -1);        // full range
        run_line(MAXC, 0, 0, 7, -1);
        run_line(0, MAXC, 3, 0, -1);
        run_line(100, 100, 140, 117, 3);       // R8 start during drawing
        run_line(50, 60, 50, 61, 1);           // R8 right before last pixel

        // constrained random segments
        for (int k = 0; k < 60; k++) begin
            int ax, ay, bx, by;
            ax = int'($urandom % 256); ay = int'($urandom % 256);
            bx = int'($urandom % 256); by = int'($urandom % 256);
            if (k % 10 == 3) by = ay;
            if (k % 10 == 7) bx = ax;
            run_line(ax, ay, bx, by, (k % 4 == 0) ? 2 : -1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule